// File: doc/BRIEF.md
# Cycle Counter Timer with Compare Interrupt

This block is a per-core interval timer. A free-running counter advances by one on every clock cycle and is visible on a read port at all times. A separate 32-bit compare register can only be written. The single register write strobe always targets the compare register, and the read data always shows the counter, so one register address serves both. Each core carries its own instance, and the instances are not kept in step with one another.

The block compares the low 32 bits of the counter with the compare register. On equality it sets a sticky pending flag. The flag drives an interrupt output through a mask enable. Software services the interrupt with an acknowledge pulse, or re-arms the timer by writing a new compare value, which also clears the flag. Only the low counter bits take part in the match. A compare value written behind the counter therefore fires only after those bits wrap round to it, which takes about four seconds at 1 GHz.

The counter width is a parameter of 32 or 64 bits. Further parameters set the reset values of the counter and the compare register.

Top module: `cycle_match_timer`

## Requirements
- R1: Once out of reset, the counter grows by exactly one on every clock edge and wraps modulo 2^CNT_W.
- R2: While rst_n is low at a clock edge, the counter loads CNT_INIT (default zero), the compare register loads CMP_INIT (default all ones) and the pending flag clears. With the default compare value, pending rises one edge after the low counter half reaches 32'hFFFF_FFFF.
- R3: A cycle with reg_wr high loads reg_wdata into the compare register at that edge. The counter keeps its R1 sequence, so the write never alters it.
- R4: reg_rdata shows the full current counter value in every cycle, with no read strobe.
- R5: When the low 32 counter bits equal the compare register during a cycle, irq_pending is 1 after the following edge and not before. The counter bits above bit 31 play no part in the match.
- R6: A compare value written below the current low counter bits leaves irq_pending at 0 until those bits wrap round to it.
- R7: irq_pending stays set until cleared. An irq_ack pulse clears it at the next edge, unless a match occurs in that same cycle.
- R8: A compare write clears irq_pending at its edge. This clear takes priority over a match on the old compare value in the same cycle.
- R9: A match in the same cycle as irq_ack leaves irq_pending set.
- R10: irq equals irq_pending AND irq_enable, and it follows irq_enable within the same cycle. irq_pending reports the flag whatever the mask.
- R11: With CNT_W = 64, the upper counter half takes the carry from the lower half when the lower half wraps. With CNT_W = 32, the whole counter takes part in the match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter ticks on every rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe; loads the compare register |
| reg_wdata | input | 32 | New compare value |
| reg_rdata | output | CNT_W | Current counter value |
| irq_enable | input | 1 | Interrupt mask enable, 1 lets pending through |
| irq_ack | input | 1 | Pulse that clears the pending flag |
| irq_pending | output | 1 | Sticky match flag, unmasked |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench builds two instances. The main one is 64 bits wide and starts its counter 256 cycles below the wrap of the low half. This brings within a short run the match against the reset compare value and the carry into bit 32, which would otherwise need 2^32 cycles. A second instance, 32 bits wide and reset to zero, covers the narrow variant and the default reset value. Random compare distances on the main instance probe match timing. Directed cycles line up a write or an acknowledge with a live match to settle the priorities.

// File: rtl/cmt_pkg.sv
// Shared constants and types for the cycle match timer.
// Assumes the compare register width is fixed; only the counter width varies.
package cmt_pkg;
    localparam int CMP_W = 32;
    typedef logic [CMP_W-1:0] cmp_word_t;
endpackage

// File: rtl/cmt_counter.sv
// Free-running cycle counter, split into a 32-bit low half and an optional
// upper half that advances on the low half's wrap.
// Assumes CNT_W is 32 or 64; reset is synchronous and active low.
module cmt_counter
    import cmt_pkg::*;
#(
    parameter int               CNT_W    = 64,
    parameter logic [CNT_W-1:0] CNT_INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o,
    output cmp_word_t        low_o
);
    localparam int LO_W = CMP_W;
    localparam int HI_W = CNT_W - CMP_W;

    logic [LO_W-1:0] lo_q;
    logic            live_q;

    // Low half: advance by one every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) lo_q <= CNT_INIT[LO_W-1:0];
        else        lo_q <= lo_q + LO_W'(1);
    end

    generate
        if (HI_W > 0) begin : g_hi
            logic [HI_W-1:0] hi_q;
            // Upper half: take the carry when the low half is about to wrap.
            always_ff @(posedge clk) begin
                if (!rst_n)     hi_q <= CNT_INIT[CNT_W-1:LO_W];
                else if (&lo_q) hi_q <= hi_q + HI_W'(1);
            end
            assign cnt_o = {hi_q, lo_q};
        end else begin : g_flat
            assign cnt_o = lo_q;
        end
    endgenerate

    assign low_o = lo_q;

    // Marks cycles that have a non-reset cycle behind them, for the checks.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R1 and R11: the whole counter, carry included, steps by exactly one.
    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> cnt_o == $past(cnt_o) + CNT_W'(1));
endmodule

// File: rtl/cmt_compare.sv
// Write-only compare register and equality detector against the low counter bits.
// Assumes the write strobe is a single-cycle level sampled at the clock edge.
module cmt_compare
    import cmt_pkg::*;
#(
    parameter cmp_word_t CMP_INIT = '1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  cmp_word_t wr_data,
    input  cmp_word_t cnt_low,
    output logic      match_o
);
    cmp_word_t cmp_q;
    logic      live_q;

    // Compare register: load on every write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     cmp_q <= CMP_INIT;
        else if (wr_en) cmp_q <= wr_data;
    end

    // Equality on the low counter bits only.
    assign match_o = (cnt_low == cmp_q);

    // Marks cycles with a non-reset cycle behind them.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R3: a write lands in the compare register at its edge.
    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(wr_en) |-> cmp_q == $past(wr_data));

    // R3: without a write the compare register holds.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && !$past(wr_en) |-> $stable(cmp_q));
endmodule

// File: rtl/cmt_pending.sv
// Sticky pending flag: set by a match, cleared by acknowledge or compare write.
// Assumes priority write-clear over match-set over acknowledge-clear.
module cmt_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic match_i,
    input  logic wr_i,
    input  logic ack_i,
    output logic pend_o
);
    logic pend_q;
    logic live_q;

    // Flag update in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (wr_i)    pend_q <= 1'b0;
        else if (match_i) pend_q <= 1'b1;
        else if (ack_i)   pend_q <= 1'b0;
    end

    assign pend_o = pend_q;

    // Marks cycles with a non-reset cycle behind them.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R5 and R9: a match without a write sets the flag, even with ack present.
    assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(match_i && !wr_i) |-> pend_o);

    // R8: a compare write always leaves the flag clear.
    assert_wrclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(wr_i) |-> !pend_o);

    // R7: an acknowledge with no match or write clears the flag.
    assert_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(ack_i && !match_i && !wr_i) |-> !pend_o);

    // R7: with nothing to clear it, a set flag stays set.
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(pend_o && !ack_i && !wr_i) |-> pend_o);
endmodule

// File: rtl/cycle_match_timer.sv
// Per-core interval timer: a free-running counter read through the register
// port, a write-only compare register on the same port, and a masked,
// sticky interrupt raised when the low 32 counter bits equal the compare value.
// Assumes CNT_W is 32 or 64; instances on different cores run unsynchronised.
module cycle_match_timer
    import cmt_pkg::*;
#(
    parameter int               CNT_W    = 64,
    parameter logic [CNT_W-1:0] CNT_INIT = '0,
    parameter cmp_word_t        CMP_INIT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [31:0]      reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic             irq_enable,
    input  logic             irq_ack,
    output logic             irq_pending,
    output logic             irq
);
    cmp_word_t cnt_low;
    logic      match;

    cmt_counter #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_o (reg_rdata),
        .low_o (cnt_low)
    );

    cmt_compare #(.CMP_INIT(CMP_INIT)) u_compare (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_data (reg_wdata),
        .cnt_low (cnt_low),
        .match_o (match)
    );

    cmt_pending u_pending (
        .clk     (clk),
        .rst_n   (rst_n),
        .match_i (match),
        .wr_i    (reg_wr),
        .ack_i   (irq_ack),
        .pend_o  (irq_pending)
    );

    // Masked request toward the interrupt controller.
    assign irq = irq_pending & irq_enable;

    // R10: the request never rises without a pending flag behind it.
    assert_irq_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_pending);
endmodule

// File: tb/cycle_match_timer_tb.sv
`timescale 1ns/1ps
module cycle_match_timer_tb;
    localparam logic [63:0] INIT64 = 64'h0000_0000_FFFF_FF00;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr, ack, en;
    logic [31:0] wdata;
    logic [63:0] rdata;
    logic        pend, irq;
    logic        wr2;
    logic [31:0] wdata2;
    logic [31:0] rdata2;
    logic        pend2, irq2;
    logic [63:0] m64;
    logic [31:0] m32;
    int          checks = 0;
    int          fails  = 0;

    always #10 clk = ~clk;

    cycle_match_timer #(.CNT_W(64), .CNT_INIT(INIT64)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_wdata(wdata),
        .reg_rdata(rdata), .irq_enable(en), .irq_ack(ack),
        .irq_pending(pend), .irq(irq)
    );

    cycle_match_timer #(.CNT_W(32)) u_dut_w32 (
        .clk(clk), .rst_n(rst_n), .reg_wr(wr2), .reg_wdata(wdata2),
        .reg_rdata(rdata2), .irq_enable(1'b1), .irq_ack(1'b0),
        .irq_pending(pend2), .irq(irq2)
    );

    // Expected counters from R1/R2: reset value, then one step per edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m64 <= INIT64;
            m32 <= 32'd0;
        end else begin
            m64 <= m64 + 64'd1;
            m32 <= m32 + 32'd1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Write compare = low counter + d, then wait until the match cycle.
    task automatic arm(input int d);
        wr = 1'b1;
        wdata = rdata[31:0] + 32'(d);
        @(negedge clk);
        wr = 1'b0;
        repeat (d - 1) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        bit bad;
        logic [31:0] c;
        void'($urandom(32'd1234));
        rst_n = 1'b0; wr = 1'b0; ack = 1'b0; en = 1'b0; wdata = '0;
        wr2 = 1'b0; wdata2 = '0;
        repeat (3) @(negedge clk);
        // R2: reset state of both instances
        chk(rdata == INIT64, "R2", rdata, INIT64);
        chk(pend == 1'b0 && irq == 1'b0, "R2", {pend, irq}, 0);
        chk(rdata2 == 32'd0, "R2", rdata2, 0);
        rst_n = 1'b1;
        // R1/R4: counter seen through the read port after 255 edges
        repeat (255) @(negedge clk);
        chk(rdata == INIT64 + 64'd255, "R4", rdata, INIT64 + 64'd255);
        chk(pend == 1'b0, "R2", pend, 0);
        @(negedge clk);
        // R2: default compare all ones has matched; R11: carry into bit 32
        chk(pend == 1'b1, "R2", pend, 1);
        chk(rdata == 64'h1_0000_0000, "R11", rdata, 64'h1_0000_0000);
        chk(irq == 1'b0, "R10", irq, 0);
        en = 1'b1;
        #1;
        chk(irq == 1'b1, "R10", irq, 1);
        repeat (5) @(negedge clk);
        chk(pend == 1'b1, "R7", pend, 1);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk(pend == 1'b0, "R7", pend, 0);
        // R6: compare behind the counter, no pending over a long window
        c = rdata[31:0];
        wr = 1'b1; wdata = c - 32'd3;
        @(negedge clk);
        wr = 1'b0;
        bad = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (pend) bad = 1'b1;
        end
        chk(!bad, "R6", bad, 0);
        chk(rdata == m64, "R3", rdata, m64);
        // R5/R10/R7/R8: random compare distances, mask and acknowledge
        for (int i = 0; i < 150; i++) begin
            int d;
            d = int'($urandom_range(60, 2));
            en = 1'($urandom_range(1, 0));
            arm(d);
            chk(pend == 1'b0, "R8", pend, 0);
            chk(rdata == m64, "R1", rdata, m64);
            @(negedge clk);
            chk(pend == 1'b1, "R5", pend, 1);
            chk(irq == en, "R10", irq, en);
            if ($urandom_range(1, 0) == 1) begin
                ack = 1'b1;
                @(negedge clk);
                ack = 1'b0;
                chk(pend == 1'b0, "R7", pend, 0);
            end
        end
        // R8: a write in the match cycle wins, then the new value fires
        arm(20);
        wr = 1'b1; wdata = rdata[31:0] + 32'd11;
        @(negedge clk);
        wr = 1'b0;
        chk(pend == 1'b0, "R8", pend, 0);
        repeat (10) @(negedge clk);
        chk(pend == 1'b0, "R5", pend, 0);
        @(negedge clk);
        chk(pend == 1'b1, "R5", pend, 1);
        // R9: an acknowledge in the match cycle loses to the match
        arm(15);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk(pend == 1'b1, "R9", pend, 1);
        // R11: the 32-bit instance counts and matches on its full width
        chk(rdata2 == m32, "R11", rdata2, m32);
        wr2 = 1'b1; wdata2 = rdata2 + 32'd4;
        @(negedge clk);
        wr2 = 1'b0;
        repeat (3) @(negedge clk);
        chk(pend2 == 1'b0, "R11", pend2, 0);
        @(negedge clk);
        chk(pend2 == 1'b1 && irq2 == 1'b1, "R11", {pend2, irq2}, 2'b11);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule